// File: doc/BRIEF.md
# Sticky Right Shifter with Extra Word

This block shifts a wide unsigned significand to the right. The significand is made of one or two 64-bit integer words, and one more 64-bit word sits below them. The block is built for the alignment step of a floating-point datapath. The shifted integer words come out as they are. The bits that fall off the bottom are folded into a new extra word, whose top bit is a guard bit and whose remaining bits are a sticky summary.

Within the window of the extra word, the bits that leave the integer part are kept exactly. Anything that falls below that window, and any nonzero content of the incoming extra word, is reduced to a single flag in bit 0. The shift count is unsigned and may exceed the total width. In that case the whole operand collapses to a 0/1 indicator.

The shift itself is combinational. A parameter chooses whether the result is registered behind a valid strobe or passed straight through. Rounding, normalisation and exponent handling belong to the surrounding datapath.

Top module: `sticky_shift_x`

## Requirements
- R1: When the shift count is 0, the integer output equals the integer input and the extra output equals the extra input, bit for bit.
- R2: For a count c with 0 < c < 64, the integer output is the integer input shifted right by c. Extra output bits 63 down to 64-c hold the c bits shifted out, left-aligned. Bit 0 is additionally ORed with 1 when the incoming extra word is nonzero.
- R3: For c = 64, the integer output moves down by exactly one word and its top word is zero. The extra output is the old lowest integer word, with bit 0 ORed with the nonzero flag of the incoming extra word.
- R4: With two integer words and c = 128, the integer output is zero. The extra output is the old top integer word, with bit 0 ORed with 1 when the old lower integer word or the incoming extra word is nonzero.
- R5: When c exceeds the integer width, the integer output is zero. The extra output is 1 if any input bit (integer or extra) is set, and 0 otherwise.
- R6: For 1 <= c <= integer width, extra output bit 63 equals integer input bit c-1, which is the last bit shifted off.
- R7: For 1 <= c <= integer width, extra output bits 62..0 are all zero exactly when integer input bits c-2..0 and the whole incoming extra word are all zero.
- R8: With the registered option, out_valid is 0 after reset and rises on the cycle after each cycle in which in_valid is 1. Each such result belongs to the inputs of that cycle.
- R9: With the registered option, the data outputs do not change in cycles that follow a cycle with in_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks a cycle whose inputs are to be shifted |
| in_int | input | 64*INT_WORDS | Integer words of the significand, most significant word on top |
| in_extra | input | 64 | Incoming extra word below the integer part |
| shift_cnt | input | CNT_W | Unsigned right-shift amount |
| out_valid | output | 1 | Result strobe |
| out_int | output | 64*INT_WORDS | Shifted integer words |
| out_extra | output | 64 | Guard bit in bit 63, sticky summary below it |

## Verification
The bench builds the block with two integer words, an 8-bit count and the registered output. This makes the 128-bit integer width reachable, so the exact two-word boundary at 128 can be tested, as well as counts on either side of 64. Counts are drawn from 0 to 200, which crosses every region: pass-through, within a word, across words, at each word edge and past the full width. Operands are mixed from random, sparse single-bit, all-ones and zero patterns. These patterns drive the guard bit and the sticky flag independently.

// File: rtl/sticky_shift_pkg.sv
package sticky_shift_pkg;
  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ssx_window.sv
// Exact right shift of the integer part into a window that also holds one
// extra word of shifted-out bits.
module ssx_window
  import sticky_shift_pkg::*;
#(
  parameter int INT_W = 128,
  parameter int CNT_W = 8
) (
  input  logic [INT_W-1:0] int_in,
  input  logic [CNT_W-1:0] cnt,
  output logic [INT_W-1:0] int_out,
  output word_t            win_out
);
  localparam int WIDE_W = INT_W + WORD_W;

  logic [WIDE_W-1:0] wide;

  always_comb begin
    wide    = {int_in, {WORD_W{1'b0}}} >> cnt;
    int_out = wide[WIDE_W-1:WORD_W];
    win_out = wide[WORD_W-1:0];
  end
endmodule

// File: rtl/ssx_lost.sv
// Flags integer bits that fall below the extra-word window entirely.
module ssx_lost #(
  parameter int INT_W  = 128,
  parameter int CNT_W  = 8,
  parameter int WIN_W  = 64
) (
  input  logic [INT_W-1:0] int_in,
  input  logic [CNT_W-1:0] cnt,
  output logic             lost_any
);
  logic [INT_W-1:0] below_mask;

  // bit m is lost when it ends up below the window: m + WIN_W < cnt
  always_comb begin
    for (int m = 0; m < INT_W; m++) begin
      below_mask[m] = ((m + WIN_W) < int'(cnt));
    end
    lost_any = |(int_in & below_mask);
  end
endmodule

// File: rtl/sticky_shift_x.sv
module sticky_shift_x
  import sticky_shift_pkg::*;
#(
  parameter int INT_WORDS = 2,
  parameter int CNT_W     = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [INT_WORDS*WORD_W-1:0] in_int,
  input  logic [WORD_W-1:0]           in_extra,
  input  logic [CNT_W-1:0]            shift_cnt,
  output logic                        out_valid,
  output logic [INT_WORDS*WORD_W-1:0] out_int,
  output logic [WORD_W-1:0]           out_extra
);
  localparam int INT_W = INT_WORDS * WORD_W;

  // named internal events, used by the bound checker
  logic             cnt_zero;
  logic             cnt_over;
  logic             extra_nz;
  logic             any_nz;
  logic             lost_any;
  logic [INT_W-1:0] win_int;
  word_t            win_bits;
  logic [INT_W-1:0] nxt_int;
  word_t            nxt_extra;

  ssx_window #(.INT_W(INT_W), .CNT_W(CNT_W)) u_window (
    .int_in  (in_int),
    .cnt     (shift_cnt),
    .int_out (win_int),
    .win_out (win_bits)
  );

  ssx_lost #(.INT_W(INT_W), .CNT_W(CNT_W), .WIN_W(WORD_W)) u_lost (
    .int_in   (in_int),
    .cnt      (shift_cnt),
    .lost_any (lost_any)
  );

  always_comb begin
    cnt_zero = (shift_cnt == '0);
    cnt_over = (int'(shift_cnt) > INT_W);
    extra_nz = |in_extra;
    any_nz   = extra_nz | (|in_int);
    if (cnt_zero) begin
      nxt_int   = in_int;
      nxt_extra = in_extra;
    end else if (cnt_over) begin
      nxt_int   = '0;
      nxt_extra = {{(WORD_W-1){1'b0}}, any_nz};
    end else begin
      nxt_int   = win_int;
      nxt_extra = win_bits | {{(WORD_W-1){1'b0}}, lost_any | extra_nz};
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_int   <= '0;
          out_extra <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_int   <= nxt_int;
            out_extra <= nxt_extra;
          end
        end
      end
    end else begin : g_comb
      always_comb begin
        out_valid = in_valid;
        out_int   = nxt_int;
        out_extra = nxt_extra;
      end
    end
  endgenerate
endmodule

// File: rtl/ssx_check.sv
module ssx_check #(
  parameter int INT_W   = 128,
  parameter int CNT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [INT_W-1:0] in_int,
  input logic [63:0]      in_extra,
  input logic [CNT_W-1:0] shift_cnt,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic [63:0]      out_extra,
  input logic [INT_W-1:0] nxt_int,
  input logic [63:0]      nxt_extra,
  input logic             cnt_zero,
  input logic             cnt_over,
  input logic             lost_any
);
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> (nxt_int == in_int && nxt_extra == in_extra)); // R1
  AST_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_over |-> (nxt_int == '0 && nxt_extra[63:1] == '0)); // R5
  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_over && in_int == '0 && in_extra == '0) |-> nxt_extra == '0); // R5
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_zero && !cnt_over && lost_any) |-> nxt_extra[0]); // R7
  AST_EXTRA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_zero && in_extra != '0) |-> nxt_extra != '0); // R7

  generate
    if (REG_OUT) begin : g_seq
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
      AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
      AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_int) && $stable(out_extra))); // R9
    end
  endgenerate
endmodule

bind sticky_shift_x ssx_check #(
  .INT_W(INT_W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)
) u_ssx_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
  .in_extra(in_extra), .shift_cnt(shift_cnt), .out_valid(out_valid),
  .out_int(out_int), .out_extra(out_extra), .nxt_int(nxt_int),
  .nxt_extra(nxt_extra), .cnt_zero(cnt_zero), .cnt_over(cnt_over),
  .lost_any(lost_any)
);

// File: tb/sticky_shift_x_test.sv
`timescale 1ns/1ps
module sticky_shift_x_test;
  localparam int NW = 2;
  localparam int W  = NW * 64;
  localparam int CW = 8;

  typedef struct {
    logic [W-1:0] a;
    logic [63:0]  e;
    int           c;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_int = '0;
  logic [63:0]   in_extra = '0;
  logic [CW-1:0] shift_cnt = '0;
  logic          out_valid;
  logic [W-1:0]  out_int;
  logic [63:0]   out_extra;

  int checks = 0;
  int errors = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  sticky_shift_x #(.INT_WORDS(NW), .CNT_W(CW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
    .in_extra(in_extra), .shift_cnt(shift_cnt), .out_valid(out_valid),
    .out_int(out_int), .out_extra(out_extra)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // bit-by-bit model of the requirements
  function automatic void model(input logic [W-1:0] a, input logic [63:0] e,
                                input int c, output logic [W-1:0] zi,
                                output logic [63:0] ze);
    bit st;
    zi = '0;
    ze = '0;
    if (c == 0) begin
      zi = a;
      ze = e;
    end else if (c > W) begin
      ze[0] = (a != '0) || (e != '0);
    end else begin
      for (int k = 0; k < W; k++) if (k + c < W) zi[k] = a[k + c];
      for (int j = 0; j < 64; j++) if (c - 1 - j >= 0) ze[63 - j] = a[c - 1 - j];
      st = (e != '0);
      for (int m = 0; m < W; m++) if (m < c - 64 && a[m]) st = 1'b1;
      ze[0] = ze[0] | st;
    end
  endfunction

  function automatic string tag_of(input int c);
    if (c == 0) return "R1";
    if (c < 64) return "R2";
    if (c == 64) return "R3";
    if (c == 128) return "R4";
    if (c > W) return "R5";
    return "R2";
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [63:0] e, input int c);
    item_t it;
    @(negedge clk);
    in_int    = a;
    in_extra  = e;
    shift_cnt = CW'(c);
    in_valid  = 1'b1;
    it.a = a; it.e = e; it.c = c;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "out_valid with no pending item (act 1 exp 0)");
      end else begin
        item_t it;
        logic [W-1:0] ei;
        logic [63:0]  ee;
        bit low_nz;
        it = sb.pop_front();
        model(it.a, it.e, it.c, ei, ee);
        check(out_int == ei, tag_of(it.c),
              $sformatf("cnt %0d int act %h exp %h", it.c, out_int, ei));
        check(out_extra == ee, tag_of(it.c),
              $sformatf("cnt %0d extra act %h exp %h", it.c, out_extra, ee));
        if (it.c >= 1 && it.c <= W) begin
          check(out_extra[63] == it.a[it.c - 1], "R6",
                $sformatf("cnt %0d guard act %b exp %b", it.c, out_extra[63], it.a[it.c - 1]));
          low_nz = (it.e != '0);
          for (int m = 0; m < it.c - 1; m++) if (it.a[m]) low_nz = 1'b1;
          check((out_extra[62:0] != '0) == low_nz, "R7",
                $sformatf("cnt %0d sticky act %b exp %b", it.c, out_extra[62:0] != '0, low_nz));
        end
      end
    end
  end

  function automatic logic [W-1:0] rnd_w();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end (act hung exp done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] a;
    logic [63:0]  e;
    logic [W-1:0] held_i;
    logic [63:0]  held_e;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_int == '0 && out_extra == '0, "R8",
          $sformatf("reset state act %b/%h exp 0/0", out_valid, out_extra));
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R8", "idle after reset act 1 exp 0");

    // directed boundaries
    drive({64'h8000_0000_0000_0001, 64'hF0F0_0000_0000_0003}, 64'h0, 0);    // R1
    drive({64'h1234, 64'h5678}, 64'hABCD, 0);                                // R1
    drive({64'h0, 64'h0000_0000_0000_0001}, 64'h0, 1);                      // R2 guard
    drive({64'h0, 64'h0000_0000_0000_0002}, 64'h0, 2);                      // R2 guard only
    drive({64'h0, 64'h0000_0000_0000_0001}, 64'h0, 2);                      // R7 sticky
    drive({64'h0, 64'h8000_0000_0000_0000}, 64'h1, 63);                     // R2
    drive({64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_1234_5678}, 64'h2, 64);  // R3
    drive({64'h1, 64'h0}, 64'h0, 64);                                        // R3
    drive({64'hFEED_0000_0000_0001, 64'h0}, 64'h0, 128);                    // R4
    drive({64'hFEED_0000_0000_0001, 64'h1}, 64'h0, 128);                    // R4
    drive({64'h8000_0000_0000_0000, 64'h0}, 64'h4, 128);                    // R4
    drive({64'h0, 64'h1}, 64'h0, 129);                                       // R5
    drive('0, 64'h0, 200);                                                   // R5 zero
    drive('0, 64'h8000_0000_0000_0000, 255);                                 // R5 extra only
    drive('1, '1, 127);                                                      // R6/R7
    // random mix
    for (int n = 0; n < 400; n++) begin
      case (n % 4)
        0: a = rnd_w();
        1: begin a = '0; a[$urandom_range(W - 1, 0)] = 1'b1; end
        2: a = '1;
        default: a = (n % 8 == 3) ? '0 : rnd_w();
      endcase
      e = ($urandom_range(2, 0) == 0) ? 64'h0 : {$urandom, $urandom};
      drive(a, e, $urandom_range(200, 0));
      if (n % 37 == 0) idle(1);
    end
    idle(3);
    check(sb.size() == 0, "R8",
          $sformatf("pending results act %0d exp 0", sb.size()));

    // R9: outputs hold while in_valid is low
    held_i = out_int;
    held_e = out_extra;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_int    = rnd_w();
      in_extra  = {$urandom, $urandom};
      shift_cnt = CW'(i * 40);
    end
    @(negedge clk);
    check(out_int == held_i && out_extra == held_e, "R9",
          $sformatf("held extra act %h exp %h", out_extra, held_e));
    check(out_valid == 1'b0, "R8", "no strobe while idle act 1 exp 0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule